// File: doc/BRIEF.md
# Bit-Addressable GPIO Port with Alternate Functions

An 8-bit general-purpose I/O port that a processor sees as a single register. Software may load the whole byte or change one bit. A bit change takes the other seven bits from the output latch, never from the pins. Each pin is driven from its latch bit unless that pin's alternate-function enable is set. While the enable is set, a peripheral's output bit drives the pin instead. Other pins are not affected, and the enable may change at any time.

A bus mode hands all eight pins to an external multiplexed address/data bus. In this mode the bus output value and a single bus drive enable control every pin. The latch keeps its contents and still accepts writes. When bus mode ends, the latch drives the pins again. With the default open-drain variant, a source bit of 0 drives the pin low and a source bit of 1 releases it. The push-pull variant drives both levels.

The register read port has two paths. One returns the latch. The other returns the pin levels after a two-flop synchroniser.

Top module: `gpio_port`

## Requirements
- R1: After reset the latch holds all ones and the synchroniser holds all zeros. With alternate functions and bus mode off, every open-drain pin is then released (`pin_oe_o` = 0x00).
- R2: A byte write (`wr_byte_i` = 1) loads `wdata_i` into the latch at the next clock edge. With `rd_pin_sel_i` = 0, `rdata_o` returns the latch combinationally.
- R3: A bit write (`wr_bit_i` = 1) sets latch bit `bit_sel_i` to `wdata_i[0]` and takes the other bits from the latch, whatever the pin levels are. If a byte write and a bit write arrive in the same cycle, the byte write wins and the bit write is ignored.
- R4: With no write strobe the latch holds its value, including through bus mode. When bus mode ends, the pins are driven from the latch again in the same cycle.
- R5: When `alt_en_i[n]` = 1, pin n takes its source bit from `alt_out_i[n]` instead of the latch. Every pin whose enable is 0 still follows its latch bit. The change takes effect combinationally.
- R6: Outside bus mode, with OPEN_DRAIN = 1, `pin_o` is 0 and `pin_oe_o[n]` is the inverse of pin n's source bit. With OPEN_DRAIN = 0, `pin_o` is the source bit and `pin_oe_o` is all ones.
- R7: While `bus_mode_i` = 1, `pin_o` equals `bus_out_i` and every bit of `pin_oe_o` equals `bus_oe_i`. This overrides both the latch and the alternate functions.
- R8: With `rd_pin_sel_i` = 1, `rdata_o` returns `pin_i` as it was sampled two clock edges earlier.
- R9: Writes made during bus mode update the latch, which is readable through `rdata_o`, but they do not reach the pins until bus mode ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_byte_i | input | 1 | Whole-byte write strobe |
| wr_bit_i | input | 1 | Single-bit write strobe |
| bit_sel_i | input | 3 | Bit index for a bit write |
| wdata_i | input | 8 | Write data (bit 0 is used for bit writes) |
| rd_pin_sel_i | input | 1 | Read source: 0 latch, 1 synchronised pins |
| rdata_o | output | 8 | Register read data |
| alt_en_i | input | 8 | Per-pin alternate-function enable |
| alt_out_i | input | 8 | Per-pin alternate-function output value |
| bus_mode_i | input | 1 | External bus mode select |
| bus_out_i | input | 8 | Bus address/data output value |
| bus_oe_i | input | 1 | Bus drive enable |
| pin_i | input | 8 | Pin input levels |
| pin_o | output | 8 | Pin output values |
| pin_oe_o | output | 8 | Pin output enables |

## Verification
A corrupted latch bit appears at `pin_oe_o` in the same cycle, unless bus mode or that pin's alternate function masks it. It also appears at `rdata_o` whenever the latch path is selected. The reference model is compared on every cycle, so a fault is caught by the first cycle in which the affected bit is not masked. A bit write that takes its base value from the pins shows up as soon as the pin levels differ from the latch. A synchroniser with the wrong depth shows up on the read-pin path within two cycles of any change at `pin_i`.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    SRC_LATCH = 2'd0,
    SRC_ALT   = 2'd1,
    SRC_BUS   = 2'd2
  } pin_src_e;
endpackage

// File: rtl/gpio_latch.sv
module gpio_latch #(
  parameter int WIDTH = 8,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_byte_i,
  input  logic             wr_bit_i,
  input  logic [IDX_W-1:0] bit_sel_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] latch_o
);
  logic [WIDTH-1:0] latch_q, latch_d;

  // bit writes merge into the latch, never the pins
  always_comb begin
    latch_d = latch_q;
    if (wr_byte_i) begin
      latch_d = wdata_i;
    end else if (wr_bit_i && (int'(bit_sel_i) < WIDTH)) begin
      latch_d[bit_sel_i] = wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) latch_q <= '1;
    else         latch_q <= latch_d;
  end

  assign latch_o = latch_q;
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_drive.sv
module gpio_drive
  import gpio_port_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter bit OPEN_DRAIN = 1'b1
) (
  input  logic [WIDTH-1:0] latch_i,
  input  logic [WIDTH-1:0] alt_en_i,
  input  logic [WIDTH-1:0] alt_out_i,
  input  logic             bus_mode_i,
  input  logic [WIDTH-1:0] bus_out_i,
  input  logic             bus_oe_i,
  output logic [WIDTH-1:0] pin_o,
  output logic [WIDTH-1:0] pin_oe_o
);
  for (genvar n = 0; n < WIDTH; n++) begin : g_pin
    pin_src_e src;
    logic     val;

    always_comb begin
      if (bus_mode_i)       src = SRC_BUS;
      else if (alt_en_i[n]) src = SRC_ALT;
      else                  src = SRC_LATCH;
    end

    assign val = (src == SRC_ALT) ? alt_out_i[n] : latch_i[n];

    if (OPEN_DRAIN) begin : g_od
      // pull low only; a 1 releases the pin
      assign pin_o[n]    = (src == SRC_BUS) ? bus_out_i[n] : 1'b0;
      assign pin_oe_o[n] = (src == SRC_BUS) ? bus_oe_i : ~val;
    end else begin : g_pp
      assign pin_o[n]    = (src == SRC_BUS) ? bus_out_i[n] : val;
      assign pin_oe_o[n] = (src == SRC_BUS) ? bus_oe_i : 1'b1;
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit OPEN_DRAIN  = 1'b1,
  localparam int IDX_W      = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_byte_i,
  input  logic             wr_bit_i,
  input  logic [IDX_W-1:0] bit_sel_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             rd_pin_sel_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic [WIDTH-1:0] alt_en_i,
  input  logic [WIDTH-1:0] alt_out_i,
  input  logic             bus_mode_i,
  input  logic [WIDTH-1:0] bus_out_i,
  input  logic             bus_oe_i,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_o,
  output logic [WIDTH-1:0] pin_oe_o
);
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] pin_sync;

  gpio_latch #(.WIDTH(WIDTH)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_byte_i (wr_byte_i),
    .wr_bit_i  (wr_bit_i),
    .bit_sel_i (bit_sel_i),
    .wdata_i   (wdata_i),
    .latch_o   (latch_q)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_sync)
  );

  gpio_drive #(.WIDTH(WIDTH), .OPEN_DRAIN(OPEN_DRAIN)) u_drive (
    .latch_i    (latch_q),
    .alt_en_i   (alt_en_i),
    .alt_out_i  (alt_out_i),
    .bus_mode_i (bus_mode_i),
    .bus_out_i  (bus_out_i),
    .bus_oe_i   (bus_oe_i),
    .pin_o      (pin_o),
    .pin_oe_o   (pin_oe_o)
  );

  assign rdata_o = rd_pin_sel_i ? pin_sync : latch_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit OPEN_DRAIN  = 1'b1,
  localparam int IDX_W      = $clog2(WIDTH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_byte_i,
  input logic             wr_bit_i,
  input logic [IDX_W-1:0] bit_sel_i,
  input logic [WIDTH-1:0] wdata_i,
  input logic             rd_pin_sel_i,
  input logic [WIDTH-1:0] rdata_o,
  input logic             bus_mode_i,
  input logic [WIDTH-1:0] bus_out_i,
  input logic             bus_oe_i,
  input logic [WIDTH-1:0] pin_i,
  input logic [WIDTH-1:0] pin_o,
  input logic [WIDTH-1:0] pin_oe_o,
  input logic [WIDTH-1:0] latch_q
);
  logic [1:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_BYTE_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_byte_i |=> latch_q == $past(wdata_i)); // R2

  AST_BIT_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_bit_i && !wr_byte_i) |=> latch_q[$past(bit_sel_i)] == $past(wdata_i[0])); // R3

  AST_BIT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_bit_i && !wr_byte_i) |=>
      ((latch_q ^ $past(latch_q)) & ~(WIDTH'(1) << $past(bit_sel_i))) == '0); // R3

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_byte_i && !wr_bit_i) |=> $stable(latch_q)); // R4

  AST_BUS_OWNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_mode_i |-> (pin_o == bus_out_i && pin_oe_o == {WIDTH{bus_oe_i}})); // R7

  if (OPEN_DRAIN) begin : g_od_chk
    AST_OD_NO_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bus_mode_i |-> (pin_o == '0)); // R6
  end

  if (SYNC_STAGES == 2) begin : g_sync_chk
    AST_PIN_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_pin_sel_i && since_rst >= 2'd2) |-> rdata_o == $past(pin_i, 2)); // R8
  end
endmodule

bind gpio_port gpio_port_chk #(
  .WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES), .OPEN_DRAIN(OPEN_DRAIN)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_byte_i(wr_byte_i), .wr_bit_i(wr_bit_i),
  .bit_sel_i(bit_sel_i), .wdata_i(wdata_i), .rd_pin_sel_i(rd_pin_sel_i),
  .rdata_o(rdata_o), .bus_mode_i(bus_mode_i), .bus_out_i(bus_out_i),
  .bus_oe_i(bus_oe_i), .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
  .latch_q(latch_q)
);

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       wr_byte = 0, wr_bit = 0, rd_pin = 0, bus_mode = 0, bus_oe = 0;
  logic [2:0] sel = 0;
  logic [7:0] wdata = 0, alt_en = 0, alt_out = 0, bus_out = 0, pin_in = 0;
  logic [7:0] rdata, pin_out, pin_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  gpio_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_byte_i(wr_byte), .wr_bit_i(wr_bit),
    .bit_sel_i(sel), .wdata_i(wdata), .rd_pin_sel_i(rd_pin), .rdata_o(rdata),
    .alt_en_i(alt_en), .alt_out_i(alt_out), .bus_mode_i(bus_mode),
    .bus_out_i(bus_out), .bus_oe_i(bus_oe), .pin_i(pin_in),
    .pin_o(pin_out), .pin_oe_o(pin_oe)
  );

  // behavioural reference
  logic [7:0] m_latch = 8'hFF;
  logic [7:0] pq[$];
  initial pq = '{8'h00, 8'h00};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_latch = 8'hFF;
      pq = '{8'h00, 8'h00};
    end else begin
      if (wr_byte) m_latch = wdata;
      else if (wr_bit) m_latch[sel] = wdata[0];
      pq.push_back(pin_in);
      void'(pq.pop_front());
    end
  end

  function automatic logic [7:0] exp_src();
    return (m_latch & ~alt_en) | (alt_out & alt_en);
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rd_pin) chk(rdata, pq[0], "R8 read-pin path");
      else        chk(rdata, m_latch, "R2 read-latch path");
      if (bus_mode) begin
        chk(pin_out, bus_out, "R7 bus pin value");
        chk(pin_oe, {8{bus_oe}}, "R7 bus pin enable");
      end else begin
        chk(pin_out, 8'h00, "R6 open-drain value");
        chk(pin_oe, ~exp_src(), "R6 open-drain enable");
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic look();
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    look();
    chk(rdata, 8'hFF, "R1 reset latch");
    chk(pin_oe, 8'h00, "R1 reset pins released");
    rd_pin = 1; #1;
    chk(rdata, 8'h00, "R1 reset synchroniser");
    rd_pin = 0;

    // R2 byte write
    tick(); wr_byte = 1; wdata = 8'h5A;
    tick(); wr_byte = 0;
    look(); chk(rdata, 8'h5A, "R2 byte write");
    chk(pin_oe, 8'hA5, "R6 enable from latch");

    // R3 bit writes with pins held opposite
    pin_in = 8'h00;
    tick(); wr_bit = 1; sel = 3'd0; wdata = 8'h01;
    tick(); sel = 3'd7; wdata = 8'h01;
    tick(); sel = 3'd6; wdata = 8'h00;
    tick(); wr_bit = 0;
    look(); chk(rdata, 8'h9B, "R3 bit writes from latch");

    // R3 byte wins over simultaneous bit write
    tick(); wr_byte = 1; wr_bit = 1; sel = 3'd1; wdata = 8'h3D;
    tick(); wr_byte = 0; wr_bit = 0;
    look(); chk(rdata, 8'h3D, "R3 byte beats bit");

    // R5 alternate function on pins 0 and 2
    tick(); alt_en = 8'h05; alt_out = 8'h01;
    look(); chk(pin_oe, 8'hC6, "R5 alt pins override");
    tick(); alt_en = 8'h00;
    look(); chk(pin_oe, 8'hC2, "R5 alt released");

    // R7 / R9 bus mode
    tick(); alt_en = 8'hFF; bus_mode = 1; bus_out = 8'hA7; bus_oe = 1;
    look(); chk(pin_out, 8'hA7, "R7 bus value");
    chk(pin_oe, 8'hFF, "R7 bus enable");
    tick(); wr_byte = 1; wdata = 8'h81;
    tick(); wr_byte = 0;
    look(); chk(pin_out, 8'hA7, "R9 write hidden in bus mode");
    chk(rdata, 8'h81, "R9 latch updated in bus mode");
    tick(); bus_oe = 0;
    look(); chk(pin_oe, 8'h00, "R7 bus released");
    tick(); bus_mode = 0; alt_en = 8'h00;
    look(); chk(pin_oe, 8'h7E, "R4 latch restored after bus");

    // R4 hold
    repeat (4) tick();
    look(); chk(rdata, 8'h81, "R4 latch hold");

    // R8 two-stage sampling
    tick(); rd_pin = 1; pin_in = 8'h96;
    look(); chk(rdata, 8'h00, "R8 not yet through");
    tick(); look(); chk(rdata, 8'h00, "R8 one stage");
    tick(); look(); chk(rdata, 8'h96, "R8 two stages");

    // mixed traffic checked by the reference model
    for (int i = 0; i < 400; i++) begin
      tick();
      wr_byte  = ($urandom_range(0, 3) == 0);
      wr_bit   = ($urandom_range(0, 2) == 0);
      sel      = 3'($urandom_range(0, 7));
      wdata    = 8'($urandom);
      rd_pin   = 1'($urandom);
      alt_en   = 8'($urandom) & 8'($urandom);
      alt_out  = 8'($urandom);
      bus_mode = ($urandom_range(0, 4) == 0);
      bus_out  = 8'($urandom);
      bus_oe   = 1'($urandom);
      pin_in   = 8'($urandom);
    end
    tick(); wr_byte = 0; wr_bit = 0;
    look();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule